// File: doc/BRIEF.md
# ADC Input Selection Shadow Register

This block sits between the software-visible channel and reference select field of an analog-to-digital converter and the value that actually steers the analog multiplexer. Software writes a temporary copy whenever it likes, and can always read it back. While the converter is idle, the active selection follows the temporary copy. When a conversion takes hold, the active selection freezes so that the sampled input stays put for the whole acquisition.

A start request arms the block. The freeze takes effect on the next ADC clock tick after the request, which models the rising ADC clock edge after the start bit is written. A selection written before that tick is therefore still picked up. The conversion sequencer raises a last-cycle indication during the final ADC clock period of the conversion. From then on the active selection follows the temporary copy again, so a new choice is in place as the completion flag rises. Channel and reference fields always freeze and release together.

Top module: `adc_sel_shadow`

## Requirements
- R1: After reset, the temporary and active channel codes and reference codes read zero, and the block is unlocked.
- R2: A CPU write (`cpu_wr` high at a clock edge) loads `cpu_ch`/`cpu_ref` into the temporary register at that edge, whatever the lock state.
- R3: While the block is unlocked, the active selection at each edge takes the temporary register value that held before that edge. It therefore trails the temporary register by one clock.
- R4: A `start_req` seen while idle arms the block, and the block stays unlocked while armed. It locks at the first clock edge with `adc_tick` high that comes after the arming edge. A tick in the same cycle as the request does not lock it.
- R5: While locked and `last_cycle` is low, the active selection does not change, even when the CPU writes the temporary register.
- R6: While locked, any cycle with `last_cycle` high loads the temporary value into the active selection at that edge.
- R7: A locked block returns to idle at an edge where `last_cycle` and `adc_tick` are both high.
- R8: `start_req` is ignored while armed, and ignored while locked unless it comes in the same cycle as `last_cycle` and `adc_tick`. In that case the block goes straight to armed.
- R9: The 5-bit channel code and the 2-bit reference code lock and release together. Neither field moves on its own while locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | CPU write strobe for the temporary register |
| cpu_ch | input | 5 | Channel code to write |
| cpu_ref | input | 2 | Reference code to write |
| adc_tick | input | 1 | One-clock enable marking an ADC clock edge |
| start_req | input | 1 | Conversion start request |
| last_cycle | input | 1 | Sequencer flag: final ADC cycle of the running conversion |
| tmp_ch | output | 5 | Temporary channel code (read-back) |
| tmp_ref | output | 2 | Temporary reference code (read-back) |
| act_ch | output | 5 | Active channel code driving the multiplexer |
| act_ref | output | 2 | Active reference code |

## Verification
The temporary register is due one edge after a write. The active selection is due one edge after the temporary value it copies, so an idle write shows up on the active outputs two edges later. The lock state changes on the edge where the qualifying tick is sampled. The bench drives every input on the falling clock edge. It then advances a reference model at the rising edge, using the inputs held there, and compares both output pairs at the next falling edge. Each comparison therefore sees exactly one registered step.

// File: rtl/adc_sel_pkg.sv
package adc_sel_pkg;

  localparam int DEF_CH_W  = 5;
  localparam int DEF_REF_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_LOCKED = 2'd2
  } lock_st_e;

  // Next lock state from current state and sequencer inputs.
  function automatic lock_st_e lock_next(lock_st_e s, logic start, logic tick, logic last);
    lock_st_e n;
    n = s;
    case (s)
      ST_IDLE:   if (start) n = ST_ARMED;
      ST_ARMED:  if (tick) n = ST_LOCKED;
      ST_LOCKED: if (last && tick) n = start ? ST_ARMED : ST_IDLE;
      default:   n = ST_IDLE;
    endcase
    return n;
  endfunction

  // Active selection follows the temporary copy in this cycle.
  function automatic logic sel_open(lock_st_e s, logic last);
    return (s != ST_LOCKED) || last;
  endfunction

endpackage

// File: rtl/sel_temp_reg.sv
module sel_temp_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] tmp_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tmp_q <= '0;
    else if (wr_en) tmp_q <= wr_data;
  end

  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tmp_q == $past(wr_data));

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tmp_q));

endmodule

// File: rtl/sel_lock_ctrl.sv
module sel_lock_ctrl
  import adc_sel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic adc_tick,
  input  logic last_cycle,
  output logic open_o
);

  lock_st_e st_q;
  lock_st_e st_d;
  logic     arm_ev;
  logic     lock_ev;
  logic     release_ev;

  assign st_d       = lock_next(st_q, start_req, adc_tick, last_cycle);
  assign open_o     = sel_open(st_q, last_cycle);
  assign arm_ev     = (st_q != ST_ARMED) && (st_d == ST_ARMED);
  assign lock_ev    = (st_q == ST_ARMED) && (st_d == ST_LOCKED);
  assign release_ev = (st_q == ST_LOCKED) && (st_d != ST_LOCKED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assert_arm_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_req) |=> st_q == ST_ARMED);

  assert_lock_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && adc_tick) |=> st_q == ST_LOCKED);

  assert_armed_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && !adc_tick) |=> st_q == ST_ARMED);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCKED && last_cycle && adc_tick && !start_req) |=> st_q == ST_IDLE);

  assert_hold_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCKED && !(last_cycle && adc_tick)) |=> st_q == ST_LOCKED);

  assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCKED && last_cycle && adc_tick && start_req) |=> st_q == ST_ARMED);

  assert_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arm_ev && !release_ev, lock_ev, release_ev && !arm_ev}));

endmodule

// File: rtl/sel_active_reg.sv
module sel_active_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_i,
  input  logic [W-1:0] tmp_i,
  output logic [W-1:0] act_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (open_i) act_q <= tmp_i;
  end

  assert_follow_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    open_i |=> act_q == $past(tmp_i));

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !open_i |=> $stable(act_q));

endmodule

// File: rtl/adc_sel_shadow.sv
module adc_sel_shadow
  import adc_sel_pkg::*;
#(
  parameter int CH_W  = DEF_CH_W,
  parameter int REF_W = DEF_REF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic [CH_W-1:0]  cpu_ch,
  input  logic [REF_W-1:0] cpu_ref,
  input  logic             adc_tick,
  input  logic             start_req,
  input  logic             last_cycle,
  output logic [CH_W-1:0]  tmp_ch,
  output logic [REF_W-1:0] tmp_ref,
  output logic [CH_W-1:0]  act_ch,
  output logic [REF_W-1:0] act_ref
);

  localparam int SEL_W = CH_W + REF_W;

  logic [SEL_W-1:0] wr_word;
  logic [SEL_W-1:0] tmp_word;
  logic [SEL_W-1:0] act_word;
  logic             sel_open_w;

  assign wr_word = {cpu_ref, cpu_ch};

  sel_temp_reg #(.W(SEL_W)) u_temp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cpu_wr),
    .wr_data (wr_word),
    .tmp_q   (tmp_word)
  );

  sel_lock_ctrl u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .adc_tick   (adc_tick),
    .last_cycle (last_cycle),
    .open_o     (sel_open_w)
  );

  sel_active_reg #(.W(SEL_W)) u_active (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_i (sel_open_w),
    .tmp_i  (tmp_word),
    .act_q  (act_word)
  );

  assign tmp_ch  = tmp_word[CH_W-1:0];
  assign tmp_ref = tmp_word[SEL_W-1:CH_W];
  assign act_ch  = act_word[CH_W-1:0];
  assign act_ref = act_word[SEL_W-1:CH_W];

  assert_fields_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_open_w |=> ($stable(act_ch) && $stable(act_ref)));

  assert_fields_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_open_w |=> (act_ch == $past(tmp_ch) && act_ref == $past(tmp_ref)));

endmodule

// File: tb/sim_adc_sel_shadow.sv
module sim_adc_sel_shadow;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [4:0] cpu_ch = '0;
  logic [1:0] cpu_ref = '0;
  logic       adc_tick = 1'b0;
  logic       start_req = 1'b0;
  logic       last_cycle = 1'b0;
  logic [4:0] tmp_ch, act_ch;
  logic [1:0] tmp_ref, act_ref;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model: 0 idle, 1 armed, 2 locked
  int       m_st = 0;
  logic [6:0] m_tmp = '0;
  logic [6:0] m_act = '0;

  always #4 clk = ~clk;

  adc_sel_shadow u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_ch(cpu_ch), .cpu_ref(cpu_ref),
    .adc_tick(adc_tick), .start_req(start_req), .last_cycle(last_cycle),
    .tmp_ch(tmp_ch), .tmp_ref(tmp_ref), .act_ch(act_ch), .act_ref(act_ref)
  );

  function automatic bit model_open(int st, logic last);
    return (st != 2) || (last == 1'b1);
  endfunction

  function automatic int model_next(int st, logic start, logic tick, logic last);
    if (st == 0) return start ? 1 : 0;
    if (st == 1) return tick ? 2 : 1;
    if (last && tick) return start ? 1 : 0;
    return 2;
  endfunction

  task automatic check(string tag, logic [6:0] got, logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // Inputs applied at a falling edge, model advanced at the rising edge,
  // outputs compared at the following falling edge.
  task automatic step(bit wr, logic [4:0] ch, logic [1:0] rf,
                      bit tick, bit start, bit last, string act_tag);
    cpu_wr = wr; cpu_ch = ch; cpu_ref = rf;
    adc_tick = tick; start_req = start; last_cycle = last;
    @(posedge clk);
    if (model_open(m_st, last)) m_act = m_tmp;
    if (wr) m_tmp = {rf, ch};
    m_st = model_next(m_st, start, tick, last);
    @(negedge clk);
    check("R2 temp", {tmp_ref, tmp_ch}, m_tmp);
    check(act_tag, {act_ref, act_ch}, m_act);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset temp", {tmp_ref, tmp_ch}, 7'h00);
    check("R1 reset active", {act_ref, act_ch}, 7'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // idle: write then follow one edge later
    step(1, 5'h15, 2'd2, 0, 0, 0, "R3 idle follow");
    step(0, 5'h00, 2'd0, 0, 0, 0, "R3 idle follow");
    check("R3 active equals written", {act_ref, act_ch}, {2'd2, 5'h15});

    // start with tick in same cycle: only arms
    step(0, 0, 0, 1, 1, 0, "R4 arm");
    step(1, 5'h0a, 2'd1, 0, 0, 0, "R4 armed transparent");
    step(0, 0, 0, 0, 1, 0, "R8 start ignored while armed");
    step(0, 0, 0, 1, 0, 0, "R4 lock edge");
    check("R4 captured pre-lock write", {act_ref, act_ch}, {2'd1, 5'h0a});
    step(1, 5'h1f, 2'd3, 1, 0, 0, "R5 locked hold");
    step(1, 5'h03, 2'd0, 0, 1, 0, "R8 start ignored while locked");
    step(0, 0, 0, 1, 0, 0, "R9 fields frozen");
    check("R9 both fields kept", {act_ref, act_ch}, {2'd1, 5'h0a});
    // last cycle without tick: reopens
    step(0, 0, 0, 0, 0, 1, "R6 last cycle load");
    check("R6 active loaded", {act_ref, act_ch}, {2'd0, 5'h03});
    // last + tick + start: rearm
    step(1, 5'h11, 2'd2, 1, 1, 1, "R8 rearm");
    step(0, 0, 0, 1, 0, 0, "R4 relock");
    step(1, 5'h04, 2'd3, 0, 0, 0, "R5 locked hold");
    step(0, 0, 0, 1, 0, 1, "R7 release");
    step(1, 5'h07, 2'd1, 0, 0, 0, "R7 idle again");
    step(0, 0, 0, 0, 0, 0, "R7 idle follow");
    check("R7 follows after release", {act_ref, act_ch}, {2'd1, 5'h07});

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit wr, tk, st, ls;
      wr = ($urandom % 3) == 0;
      tk = ($urandom % 4) == 0;
      st = ($urandom % 8) == 0;
      ls = (m_st == 2) && (($urandom % 6) == 0);
      step(wr, 5'($urandom), 2'($urandom), tk, st, ls,
           (m_st == 2 && !ls) ? "R5 random locked" : "R3 random open");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule